// File: doc/BRIEF.md
# Hard Reset Suspend-Plane Sequencer

This block sits beside an I/O write decoder and watches for writes to the reset control port at I/O address `0x0CF9`. A write that sets both the hard-reset select bit and the reset-go bit starts a hard reset. All three suspend-plane controls are pulled low at once and held there while a slow real-time clock, brought into the system clock domain, advances through a fixed number of rising edges. The controls are then released and the block issues one reboot strobe.

The strobe reports which of two paths the reset took. If the power-good input stayed high for the whole pulse, the result is a warm reboot. If power-good dropped at any point, the power planes collapsed and the system must take the cold-boot path. A write that sets only the reset-go bit asks for a soft reset. That gives a single strobe and leaves the suspend controls alone. While a hard reset sequence is running, the block ignores all writes.

The controller has four states:

- **IDLE** waits for a write.
- **PULSE** holds the suspend controls low and counts slow-clock edges.
- **WARM** and **COLD** each last one cycle and drive their strobe.

The transitions are:

- IDLE→PULSE on a hard request.
- PULSE→WARM on the terminal edge when no power loss was seen.
- PULSE→COLD on the terminal edge when a power loss was seen.
- WARM→IDLE and COLD→IDLE unconditionally.

Top module: `hrst_seq`

## Requirements
- R1: While reset is asserted and afterwards until the first request, `sus_a_n`, `sus_b_n` and `sus_c_n` are high, and `warm_reset`, `cold_boot` and `soft_reset` are low.
- R2: A write in IDLE to address `0x0CF9` whose data has bit 2 = 1 and bit 1 = 1 drives all three suspend outputs low from the next clock edge. The three outputs are always equal.
- R3: The suspend outputs are released on the clock edge at which the 4th synchronised rising edge of `rtc_clk` since the request is seen. This gives a low time of three to four `rtc_clk` periods, plus up to three system cycles of synchroniser delay.
- R4: If `pwr_good` is high in every cycle of the pulse, `warm_reset` is high for exactly one cycle, in the cycle the suspend outputs go high.
- R5: If `pwr_good` is low in any cycle of the pulse, including the cycle holding the terminal edge, `cold_boot` fires instead of `warm_reset`, with the same timing.
- R6: A write in IDLE to `0x0CF9` with bit 2 = 1 and bit 1 = 0 gives a one-cycle `soft_reset` on the next clock edge. The suspend outputs stay high.
- R7: A write to any other address, or with bit 2 = 0, has no effect on any output.
- R8: Writes that arrive outside IDLE are ignored: they give no strobe and do not restart or extend the pulse.
- R9: At most one of the three strobes is high in any cycle, and each request produces exactly one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| rtc_clk | input | 1 | Slow real-time clock, asynchronous to `clk` |
| pwr_good | input | 1 | Power-good from the supply |
| sus_a_n | output | 1 | Suspend-plane control A, active low |
| sus_b_n | output | 1 | Suspend-plane control B, active low |
| sus_c_n | output | 1 | Suspend-plane control C, active low |
| warm_reset | output | 1 | One-cycle warm reboot strobe |
| cold_boot | output | 1 | One-cycle cold-boot strobe |
| soft_reset | output | 1 | One-cycle soft reset strobe |

## Verification
The decision between warm and cold and the end of the pulse can fall in the same cycle. This happens when `pwr_good` drops in exactly the cycle in which the terminal synchronised slow-clock edge is seen. The bench drives `rtc_clk` itself, so it knows that the edge reaches the controller two clock edges after the rise. It places a one-cycle power-good glitch either on that cycle or on the cycle just after it. The scoreboard expects `cold_boot` for the first placement and `warm_reset` for the second.

// File: rtl/hrst_pkg.sv
package hrst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WARM  = 2'd2,
        ST_COLD  = 2'd3
    } hrst_state_e;

    // control register bit positions
    localparam int CTRL_GO_BIT   = 2;
    localparam int CTRL_HARD_BIT = 1;
endpackage

// File: rtl/hrst_sync.sv
module hrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_in};
    end

    // chain[STAGES] holds the previous synchronised value
    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/hrst_decode.sv
module hrst_decode #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0CF9
) (
    input  logic              enable,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              hard_req,
    output logic              soft_req
);
    import hrst_pkg::*;

    logic hit;
    assign hit      = enable && wr && (addr == CTRL_ADDR) && data[CTRL_GO_BIT];
    assign hard_req = hit &&  data[CTRL_HARD_BIT];
    assign soft_req = hit && !data[CTRL_HARD_BIT];
endmodule

// File: rtl/hrst_edge_cnt.sv
module hrst_edge_cnt #(
    parameter int EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int CNT_W = $clog2(EDGES + 1);

    logic [CNT_W-1:0] cnt;

    assign last = tick && (cnt == CNT_W'(EDGES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else if (tick)       cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hrst_seq.sv
module hrst_seq #(
    parameter int                ADDR_W      = 16,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_ADDR   = 16'h0CF9,
    parameter int                PULSE_EDGES = 4,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic              rtc_clk,
    input  logic              pwr_good,
    output logic              sus_a_n,
    output logic              sus_b_n,
    output logic              sus_c_n,
    output logic              warm_reset,
    output logic              cold_boot,
    output logic              soft_reset
);
    import hrst_pkg::*;

    hrst_state_e state, state_nx;
    logic        hard_req, soft_req;
    logic        rtc_rise, pulse_done;
    logic        pg_lost, soft_q;
    logic        in_pulse;

    assign in_pulse = (state == ST_PULSE);

    hrst_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .enable   (state == ST_IDLE),
        .wr       (io_wr),
        .addr     (io_addr),
        .data     (io_wdata),
        .hard_req (hard_req),
        .soft_req (soft_req)
    );

    hrst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (rtc_clk),
        .rise     (rtc_rise)
    );

    hrst_edge_cnt #(.EDGES(PULSE_EDGES)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!in_pulse),
        .tick  (rtc_rise && in_pulse),
        .last  (pulse_done)
    );

    // power loss seen at any point of the pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !in_pulse) pg_lost <= 1'b0;
        else if (!pwr_good)      pg_lost <= 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (hard_req) state_nx = ST_PULSE;
            ST_PULSE: if (pulse_done)
                          state_nx = (pg_lost || !pwr_good) ? ST_COLD : ST_WARM;
            ST_WARM:  state_nx = ST_IDLE;
            ST_COLD:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            soft_q <= 1'b0;
        end else begin
            state  <= state_nx;
            soft_q <= soft_req;
        end
    end

    always_comb begin
        sus_a_n    = !in_pulse;
        sus_b_n    = !in_pulse;
        sus_c_n    = !in_pulse;
        warm_reset = (state == ST_WARM);
        cold_boot  = (state == ST_COLD);
        soft_reset = soft_q;
    end
endmodule

// File: rtl/hrst_seq_chk.sv
module hrst_seq_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'h0CF9
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 io_wr,
    input logic [ADDR_W-1:0]    io_addr,
    input logic [7:0]           io_wdata,
    input hrst_pkg::hrst_state_e state,
    input logic                 sus_a_n,
    input logic                 sus_b_n,
    input logic                 sus_c_n,
    input logic                 warm_reset,
    input logic                 cold_boot,
    input logic                 soft_reset
);
    import hrst_pkg::*;

    AST_SUS_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sus_a_n == sus_b_n) && (sus_b_n == sus_c_n)); // R2

    AST_HARD_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && io_wr && io_addr == CTRL_ADDR && io_wdata[2] && io_wdata[1])
        |=> !sus_a_n); // R2

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({warm_reset, cold_boot, soft_reset})); // R9

    AST_RELEASE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sus_a_n) |-> (warm_reset || cold_boot)); // R4

    AST_STROBE_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_reset || cold_boot) |-> $rose(sus_a_n)); // R5

    AST_SOFT_KEEPS_SUS: assert property (@(posedge clk) disable iff (!rst_n)
        soft_reset |-> sus_a_n); // R6

    AST_WARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        warm_reset |=> !warm_reset); // R4

    AST_BUSY_NO_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> !soft_reset); // R8
endmodule

bind hrst_seq hrst_seq_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .io_wdata   (io_wdata[7:0]),
    .state      (state),
    .sus_a_n    (sus_a_n),
    .sus_b_n    (sus_b_n),
    .sus_c_n    (sus_c_n),
    .warm_reset (warm_reset),
    .cold_boot  (cold_boot),
    .soft_reset (soft_reset)
);

// File: tb/tb_hrst_seq.sv
module tb_hrst_seq;
    localparam int RTC_P = 20;
    localparam logic [15:0] RST_PORT = 16'h0CF9;
    localparam int K_WARM = 1, K_COLD = 2, K_SOFT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        rtc_clk = 1'b0;
    logic        pwr_good = 1'b1;
    logic        sus_a_n, sus_b_n, sus_c_n;
    logic        warm_reset, cold_boot, soft_reset;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    hrst_seq dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .rtc_clk(rtc_clk), .pwr_good(pwr_good),
        .sus_a_n(sus_a_n), .sus_b_n(sus_b_n), .sus_c_n(sus_c_n),
        .warm_reset(warm_reset), .cold_boot(cold_boot), .soft_reset(soft_reset)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // one slow-clock period: low half then high half; optional write and glitch
    task automatic rtc_period(input int drop_at, input int wr_at, input logic [7:0] wd);
        for (int i = 0; i < RTC_P/2; i++) begin
            if (i == wr_at) begin io_wr = 1'b1; io_addr = RST_PORT; io_wdata = wd; end
            else io_wr = 1'b0;
            @(negedge clk);
        end
        io_wr = 1'b0;
        rtc_clk = 1'b1;
        for (int i = 1; i <= RTC_P/2; i++) begin
            @(negedge clk);
            pwr_good = (i != drop_at);
        end
        pwr_good = 1'b1;
        rtc_clk = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // monitor: pops expected strobes and measures suspend low time
    initial begin
        int low_len;
        int kind;
        low_len = 0;
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                if ($countones({warm_reset, cold_boot, soft_reset}) > 1)
                    chk(1'b0, "R9", "several strobes", $countones({warm_reset, cold_boot, soft_reset}), 1);
                else if (warm_reset || cold_boot || soft_reset) begin
                    kind = warm_reset ? K_WARM : (cold_boot ? K_COLD : K_SOFT);
                    if (exp_q.size() == 0)
                        chk(1'b0, "R7/R8", "unexpected strobe kind", kind, 0);
                    else begin
                        int e;
                        e = exp_q.pop_front();
                        chk(kind == e, "R4/R5/R6 R9", "strobe kind", kind, e);
                    end
                end
                if (!sus_a_n) low_len++;
                else if (low_len > 0) begin
                    chk(low_len >= 3*RTC_P && low_len <= 4*RTC_P + 4, "R3",
                        "suspend low cycles", low_len, 4*RTC_P);
                    low_len = 0;
                end
                if (!(sus_a_n == sus_b_n && sus_b_n == sus_c_n))
                    chk(1'b0, "R2", "suspend outputs differ", {sus_a_n, sus_b_n, sus_c_n}, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        chk({sus_a_n, sus_b_n, sus_c_n} == 3'b111, "R1", "sus in reset", {sus_a_n, sus_b_n, sus_c_n}, 7);
        chk({warm_reset, cold_boot, soft_reset} == 3'b000, "R1", "strobes in reset",
            {warm_reset, cold_boot, soft_reset}, 0);
        rst_n = 1'b1;
        idle(5);
        chk(sus_a_n && !warm_reset && !cold_boot && !soft_reset, "R1", "idle after reset", sus_a_n, 1);

        // R2 / R4: warm reboot
        exp_q.push_back(K_WARM);
        io_write(RST_PORT, 8'h06);
        chk(!sus_a_n && !sus_b_n && !sus_c_n, "R2", "sus low next edge", sus_a_n, 0);
        for (int p = 0; p < 4; p++) rtc_period(-1, -1, 8'h00);
        idle(10);
        chk(exp_q.size() == 0, "R4", "warm strobe seen", exp_q.size(), 0);

        // R5: one-cycle power loss mid pulse
        exp_q.push_back(K_COLD);
        io_write(RST_PORT, 8'h0E);
        rtc_period(-1, -1, 8'h00);
        rtc_period(5, -1, 8'h00);
        rtc_period(-1, -1, 8'h00);
        rtc_period(-1, -1, 8'h00);
        idle(10);
        chk(exp_q.size() == 0, "R5", "cold strobe seen", exp_q.size(), 0);

        // R5: power loss in the terminal-edge cycle
        exp_q.push_back(K_COLD);
        io_write(RST_PORT, 8'h06);
        for (int p = 0; p < 3; p++) rtc_period(-1, -1, 8'h00);
        rtc_period(2, -1, 8'h00);
        idle(10);
        chk(exp_q.size() == 0, "R5", "coincident loss gives cold", exp_q.size(), 0);

        // R4: power loss one cycle after the terminal edge
        exp_q.push_back(K_WARM);
        io_write(RST_PORT, 8'h06);
        for (int p = 0; p < 3; p++) rtc_period(-1, -1, 8'h00);
        rtc_period(3, -1, 8'h00);
        idle(10);
        chk(exp_q.size() == 0, "R4", "late loss stays warm", exp_q.size(), 0);

        // R6: soft reset
        exp_q.push_back(K_SOFT);
        io_write(RST_PORT, 8'h04);
        chk(sus_a_n && sus_b_n && sus_c_n, "R6", "sus stays high on soft", sus_a_n, 1);
        idle(5);
        chk(exp_q.size() == 0, "R6", "soft strobe seen", exp_q.size(), 0);

        // R7: non-matching writes
        io_write(16'h0CF8, 8'h06);
        io_write(16'h1CF9, 8'h06);
        io_write(RST_PORT, 8'h02);
        io_write(RST_PORT, 8'h00);
        chk(sus_a_n, "R7", "sus high after ignored writes", sus_a_n, 1);
        idle(5);
        chk(!warm_reset && !cold_boot && !soft_reset && sus_a_n, "R7", "no effect", soft_reset, 0);

        // R8: writes during the pulse are ignored
        exp_q.push_back(K_WARM);
        io_write(RST_PORT, 8'h06);
        rtc_period(-1, 3, 8'h04);
        rtc_period(-1, 3, 8'h06);
        rtc_period(-1, -1, 8'h00);
        rtc_period(-1, -1, 8'h00);
        idle(10);
        chk(exp_q.size() == 0, "R8", "single warm despite busy writes", exp_q.size(), 0);
        chk(sus_a_n, "R8", "pulse not extended", sus_a_n, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule